// File: doc/BRIEF.md
# Pipelined Packed Signed 16-bit Multiplier

This block multiplies four pairs of signed 16-bit words packed side by side in two 64-bit operands. Word i of an operand sits at bits 16i+15:16i. Every product is a full 32-bit signed value. A two-bit mode chooses the shape of the 64-bit result:

- the low half of each product, one 16-bit lane per product;
- the high half of each product, one 16-bit lane per product;
- two 32-bit sums, each made from an adjacent pair of products.

The unit is fully pipelined. A new operation can be presented on every clock cycle. Each result appears exactly three cycles after its operation is accepted. There is no stall, and results leave in the order the operations entered. The mode travels down the pipeline with its operands, so operations in different modes can follow each other on consecutive cycles. Accumulation across operations is left to logic outside the block.

Top module: `pmul16_unit`

## Requirements
- R1: Each of the four multiplies treats its two 16-bit words as signed two's-complement values and forms a 32-bit signed product. For example, FFFFh times 0002h gives FFFFFFFEh.
- R2: With mode code 00, bits 16i+15:16i of the result hold bits 15:0 of product i, for each i from 0 to 3.
- R3: With mode code 01, bits 16i+15:16i of the result hold bits 31:16 of product i, for each i from 0 to 3.
- R4: With mode code 10 or 11, result bits 31:0 hold product 1 plus product 0, and result bits 63:32 hold product 3 plus product 2.
- R5: The pairwise sums wrap modulo 2^32 and do not saturate. When every operand word is 8000h, each 32-bit half of the result is 80000000h.
- R6: An operation is accepted on a rising edge where inVld is high. Its result and a high outVld are visible after the third rising edge that follows, so outVld is inVld delayed by three cycles.
- R7: One operation is accepted every cycle without any stall. Results come out in issue order, and each result uses the mode it was issued with, even when the modes of consecutive operations differ.
- R8: While rst is high, all pipeline valid bits are cleared. Operations that were in flight when reset arrived never produce an outVld pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inVld | input | 1 | Operation present on opA, opB and mode |
| opA | input | 64 | First operand, four signed 16-bit words |
| opB | input | 64 | Second operand, four signed 16-bit words |
| mode | input | 2 | 00 low halves, 01 high halves, 1x pairwise sums |
| outVld | output | 1 | result holds a finished operation |
| result | output | 64 | Packed result laid out according to the issued mode |

## Verification
The assertions check on every cycle that each valid bit advances exactly one stage per clock. They also check that each formatted result matches the products held one stage earlier: the correct half in the two half-product modes, and the wrapped pairwise sum in the sum mode. The scoreboard compares the full path from the ports against a separate model of the arithmetic, and it checks the cycle on which each result arrives. Only the bench scenarios show signed corner operands, the 8000h wrap, back-to-back operations in mixed modes, and the discarding of in-flight work by reset.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [1:0] {
    MODE_LO   = 2'b00,
    MODE_HI   = 2'b01,
    MODE_SUM  = 2'b10,
    MODE_SUMX = 2'b11
  } pmul_mode_e;

  // Strobes from the control pipeline to the datapath.
  typedef struct packed {
    logic       capture;  // load operand stage
    logic       product;  // load product stage
    logic       format;   // load result stage
    pmul_mode_e fmtMode;  // mode of the operation being formatted
  } pmul_strobe_t;

endpackage

// File: rtl/pmul_ctrl.sv
module pmul_ctrl
  import pmul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inVld,
  input  logic [1:0]   inMode,
  output pmul_strobe_t strb,
  output logic         outVld
);

  logic       vldS1, vldS2, vldS3;
  pmul_mode_e modeS1, modeS2;

  always_ff @(posedge clk) begin
    if (rst) begin
      vldS1 <= 1'b0;
      vldS2 <= 1'b0;
      vldS3 <= 1'b0;
    end else begin
      vldS1 <= inVld;
      vldS2 <= vldS1;
      vldS3 <= vldS2;
    end
  end

  // Mode follows its operands stage by stage.
  always_ff @(posedge clk) begin
    if (inVld) modeS1 <= pmul_mode_e'(inMode);
    if (vldS1) modeS2 <= modeS1;
  end

  always_comb begin
    strb.capture = inVld;
    strb.product = vldS1;
    strb.format  = vldS2;
    strb.fmtMode = modeS2;
  end

  assign outVld = vldS3;

  // R6: each valid bit moves one stage per cycle
  p_stage1_r6: assert property (@(posedge clk) disable iff (rst)
    inVld |=> vldS1);
  p_stage1_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !inVld |=> !vldS1);
  p_outvld_r6: assert property (@(posedge clk) disable iff (rst)
    vldS2 == $past(vldS1) && outVld == $past(vldS2));

  // R7: the mode seen by the formatter is the one issued two cycles earlier
  p_mode_r7: assert property (@(posedge clk) disable iff (rst)
    inVld |=> ##1 (strb.fmtMode == pmul_mode_e'($past(inMode, 2))));

  // R8: valid bits are clear on the cycle after reset
  p_reset_r8: assert property (@(posedge clk)
    rst |=> !outVld && !strb.format && !strb.product);

endmodule

// File: rtl/pmul_dpath.sv
module pmul_dpath
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pmul_strobe_t            strb,
  input  logic [LANE_W*LANES-1:0] opA,
  input  logic [LANE_W*LANES-1:0] opB,
  output logic [LANE_W*LANES-1:0] result
);

  localparam int DW    = LANE_W * LANES;
  localparam int PW    = 2 * LANE_W;
  localparam int PAIRS = LANES / 2;

  logic [DW-1:0] aS1, bS1;
  logic [PW-1:0] prodS2 [LANES];
  logic [PW-1:0] prodNext [LANES];
  logic [DW-1:0] fmtNext;

  // Stage 1: operand capture.
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      aS1 <= opA;
      bS1 <= opB;
    end
  end

  // Stage 2: one signed multiplier per lane.
  for (genvar i = 0; i < LANES; i++) begin : g_mul
    logic signed [LANE_W-1:0] aLane, bLane;
    assign aLane = aS1[i*LANE_W +: LANE_W];
    assign bLane = bS1[i*LANE_W +: LANE_W];
    assign prodNext[i] = PW'(aLane * bLane);

    always_ff @(posedge clk) begin
      if (strb.product) prodS2[i] <= prodNext[i];
    end
  end

  // Stage 3: result formatting by mode.
  always_comb begin
    fmtNext = '0;
    unique case (strb.fmtMode)
      MODE_LO: begin
        for (int i = 0; i < LANES; i++)
          fmtNext[i*LANE_W +: LANE_W] = prodS2[i][LANE_W-1:0];
      end
      MODE_HI: begin
        for (int i = 0; i < LANES; i++)
          fmtNext[i*LANE_W +: LANE_W] = prodS2[i][PW-1:LANE_W];
      end
      default: begin
        for (int j = 0; j < PAIRS; j++)
          fmtNext[j*PW +: PW] = prodS2[2*j] + prodS2[2*j+1];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.format) result <= fmtNext;
  end

  // Checks of the formatted result against the stored products.
  for (genvar i = 0; i < LANES; i++) begin : g_chk_half
    // R2: low halves
    p_low_half_r2: assert property (@(posedge clk) disable iff (rst)
      strb.format && strb.fmtMode == MODE_LO |=>
        result[i*LANE_W +: LANE_W] == $past(prodS2[i][LANE_W-1:0]));
    // R3: high halves
    p_high_half_r3: assert property (@(posedge clk) disable iff (rst)
      strb.format && strb.fmtMode == MODE_HI |=>
        result[i*LANE_W +: LANE_W] == $past(prodS2[i][PW-1:LANE_W]));
    // R1: product of the captured words, sign-extended in 2*LANE_W bits
    p_signed_prod_r1: assert property (@(posedge clk) disable iff (rst)
      strb.product |=>
        $signed(prodS2[i]) ==
          $past($signed({{LANE_W{aS1[i*LANE_W+LANE_W-1]}}, aS1[i*LANE_W +: LANE_W]}) *
                $signed({{LANE_W{bS1[i*LANE_W+LANE_W-1]}}, bS1[i*LANE_W +: LANE_W]})));
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_chk_sum
    // R4 / R5: pairwise sum, wrapped to PW bits
    p_pair_sum_r4: assert property (@(posedge clk) disable iff (rst)
      strb.format && strb.fmtMode[1] |=>
        result[j*PW +: PW] == $past(PW'(prodS2[2*j] + prodS2[2*j+1])));
  end

  // Result register only changes when a formatted value is loaded.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.format |=> $stable(result));

endmodule

// File: rtl/pmul16_unit.sv
module pmul16_unit
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inVld,
  input  logic [LANE_W*LANES-1:0] opA,
  input  logic [LANE_W*LANES-1:0] opB,
  input  logic [1:0]              mode,
  output logic                    outVld,
  output logic [LANE_W*LANES-1:0] result
);

  pmul_strobe_t strb;

  pmul_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inVld  (inVld),
    .inMode (mode),
    .strb   (strb),
    .outVld (outVld)
  );

  pmul_dpath #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: tb/pmul16_unit_test.sv
module pmul16_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVld = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  mode = 2'b00;
  logic        outVld;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    int          dueCyc;
    string       tag;
  } item_t;

  item_t sb[$];

  pmul16_unit uut (
    .clk(clk), .rst(rst), .inVld(inVld), .opA(opA), .opB(opB),
    .mode(mode), .outVld(outVld), .result(result)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model of the arithmetic.
  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] m);
    logic signed [31:0] p [4];
    logic [63:0] r;
    for (int i = 0; i < 4; i++)
      p[i] = $signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]);
    r = '0;
    if (m == 2'b00)      for (int i = 0; i < 4; i++) r[i*16 +: 16] = p[i][15:0];
    else if (m == 2'b01) for (int i = 0; i < 4; i++) r[i*16 +: 16] = p[i][31:16];
    else begin
      r[31:0]  = p[0] + p[1];
      r[63:32] = p[2] + p[3];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one operation per call, back to back when called in a row.
  task automatic issue(logic [63:0] a, logic [63:0] b, logic [1:0] m, string tag);
    item_t it;
    @(negedge clk);
    inVld = 1'b1; opA = a; opB = b; mode = m;
    it.exp = model(a, b, m);
    it.dueCyc = cyc + 3;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inVld = 1'b0; opA = '0; opB = '0; mode = 2'b00;
    end
  endtask

  // Monitor: compares results with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && outVld) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected outVld actual=1 expected=0 at cycle %0d", cyc);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, result, it.exp);
        checks++;
        if (cyc != it.dueCyc) begin
          errors++;
          $display("FAIL R6 %s arrival actual=%0d expected=%0d", it.tag, cyc, it.dueCyc);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 outVld during reset", {63'd0, outVld}, 64'd0);
    rst = 1'b0;
    idle(2);
    check("R8 outVld after reset", {63'd0, outVld}, 64'd0);

    // R1 signed products, R2 low halves
    issue(64'h0002_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFB, 2'b00, "R2 low halves signed");
    idle(4);
    // R3 high halves, with a gap to show latency (R6)
    issue(64'h0002_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFB, 2'b01, "R3 high halves signed");
    idle(4);
    issue(64'h8000_8000_1234_FFFF, 64'h8000_7FFF_5678_FFFF, 2'b01, "R1 R3 extreme signs");
    idle(4);
    // R4 both sum codes
    issue(64'h0003_FFFE_0064_FF9C, 64'h0007_0005_0064_0064, 2'b10, "R4 pair sums code 10");
    issue(64'h1111_2222_3333_4444, 64'hFFFF_0002_8001_7FFF, 2'b11, "R4 pair sums code 11");
    idle(4);
    // R5 wrap
    issue(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b10, "R5 wrap 8000h");
    idle(4);
    checks++;
    if (model(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b10) !== 64'h80000000_80000000) begin
      errors++;
      $display("FAIL R5 model actual=%h expected=%h",
               model(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b10), 64'h80000000_80000000);
    end
    // R7 back-to-back mixed modes
    issue(64'hA5A5_5A5A_0F0F_F0F0, 64'h1234_8765_FFFF_0001, 2'b00, "R7 b2b lo");
    issue(64'hA5A5_5A5A_0F0F_F0F0, 64'h1234_8765_FFFF_0001, 2'b01, "R7 b2b hi");
    issue(64'hA5A5_5A5A_0F0F_F0F0, 64'h1234_8765_FFFF_0001, 2'b10, "R7 b2b sum");
    issue(64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 2'b01, "R7 b2b hi max");
    issue(64'h0001_0002_0003_0004, 64'hFFFF_FFFE_FFFD_FFFC, 2'b00, "R7 b2b lo small");
    issue(64'h7FFF_8000_7FFF_8000, 64'h7FFF_8000_8000_7FFF, 2'b11, "R7 b2b sum mix");
    idle(6);
    check("R7 scoreboard drained", 64'(sb.size()), 64'd0);

    // R8 reset discards in-flight work
    @(negedge clk);
    inVld = 1'b1; opA = 64'h1; opB = 64'h1; mode = 2'b00;
    @(negedge clk);
    inVld = 1'b0; rst = 1'b1;
    idle(2);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 no output after reset", {63'd0, outVld}, 64'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule